// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a 64-word first-in first-out buffer. Its word width can be set to 8 or 9 bits. A producer offers a word with a shift-in strobe, and the word is taken only while the block reports that it can accept input. A consumer removes the oldest word with a shift-out strobe, and the removal happens only while the block reports that a word is available. The oldest word is always shown on the data output while output-ready is high, so the consumer reads it before it strobes. Everything runs on one clock, and both strobes are sampled at the rising edge.

Two occupancy flags come out of the block. The edge flag is high when the buffer is nearly empty or nearly full. The half flag is high from half capacity upward.

Instances can be tiled to build larger buffers:
- **Wider words.** Place instances side by side and AND their ready outputs together.
- **Deeper buffers.** Chain instances. An upstream instance drives its own shift-out from its output-ready, gated by the downstream input-ready, and that same term is the downstream shift-in.

Top module: `strobe_fifo`

## Requirements
- R1: A synchronous active-high reset empties the buffer. After reset, in_rdy=1, out_rdy=0, half_flag=0 and edge_flag=1.
- R2: When shift_in=1 and in_rdy=1 at a rising edge, the word on din is stored, and out_rdy is 1 after that edge.
- R3: When shift_in=1 while in_rdy=0 (64 words held), nothing is stored and the occupancy does not change.
- R4: When shift_out=1 while out_rdy=0 (empty), the strobe is ignored and out_rdy stays 0.
- R5: Words appear on dout in exactly the order they were stored, with no loss and no duplication.
- R6: edge_flag is 1 when the occupancy is at most LOW_MARK (default 8) or at least HIGH_MARK (default 56), and 0 otherwise.
- R7: half_flag is 1 when the occupancy is 32 or more, and 0 otherwise.
- R8: Shift-in and shift-out in the same cycle, with neither blocked, leave the occupancy unchanged. When the buffer is full, only the shift-out takes effect. When it is empty, only the shift-in takes effect.
- R9: While out_rdy=1, dout shows the oldest word combinationally. It stays unchanged while no shift-out is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_in | input | 1 | Store strobe |
| din | input | WIDTH | Word to store |
| in_rdy | output | 1 | Space available |
| shift_out | input | 1 | Remove strobe |
| dout | output | WIDTH | Oldest stored word |
| out_rdy | output | 1 | Word available |
| edge_flag | output | 1 | Nearly empty or nearly full |
| half_flag | output | 1 | At least half full |

## Verification
A bench model tracks the occupancy and the word order. Random phases are run in three mixes:
- **Fill-biased.** This pushes the buffer into full and tests blocked stores against the last slot.
- **Drain-biased.** This reaches empty and tests blocked removals and the fall-through delay of the first word.
- **Balanced.** This holds the occupancy near the flag thresholds and wraps the pointers many times, which separates a correct threshold compare from an off-by-one.

Directed runs fill the buffer completely and drain it completely, strobing both lines at each extreme, so the full and empty priority rules of R8 are each seen in isolation.

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int WIDTH     = 9,
  parameter int DEPTH     = 64,
  parameter int LOW_MARK  = 8,
  parameter int HIGH_MARK = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shift_out,
  output logic [WIDTH-1:0] dout,
  output logic             out_rdy,
  output logic             edge_flag,
  output logic             half_flag
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_wr, do_rd;

  assign in_rdy    = (count != CW'(DEPTH));
  assign out_rdy   = (count != '0);
  assign do_wr     = shift_in & in_rdy;
  assign do_rd     = shift_out & out_rdy;
  assign dout      = mem[rd_ptr];
  assign half_flag = (count >= CW'(DEPTH / 2));
  assign edge_flag = (count <= CW'(LOW_MARK)) || (count >= CW'(HIGH_MARK));

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/strobe_fifo_checks.sv
module strobe_fifo_checks #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_in,
  input logic             shift_out,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic [WIDTH-1:0] dout,
  input logic             edge_flag,
  input logic             half_flag
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_rdy && !out_rdy && !half_flag && edge_flag));

  a_r2_store_makes_ready: assert property (@(posedge clk) disable iff (rst)
    (shift_in && in_rdy) |=> out_rdy);

  a_r3_full_stays_full: assert property (@(posedge clk) disable iff (rst)
    (!in_rdy && !shift_out) |=> !in_rdy);

  a_r4_empty_stays_empty: assert property (@(posedge clk) disable iff (rst)
    (!out_rdy && !shift_in) |=> !out_rdy);

  a_r7_half_implies_data: assert property (@(posedge clk) disable iff (rst)
    half_flag |-> out_rdy);

  a_r8_both_keep_flags: assert property (@(posedge clk) disable iff (rst)
    (shift_in && in_rdy && shift_out && out_rdy) |=>
      ($stable(half_flag) && $stable(edge_flag) && out_rdy && in_rdy));

  a_r9_head_holds: assert property (@(posedge clk) disable iff (rst)
    (out_rdy && !shift_out) |=> (out_rdy && $stable(dout)));
endmodule

bind strobe_fifo strobe_fifo_checks #(.WIDTH(WIDTH)) chk (
  .clk(clk), .rst(rst), .shift_in(shift_in), .shift_out(shift_out),
  .in_rdy(in_rdy), .out_rdy(out_rdy), .dout(dout),
  .edge_flag(edge_flag), .half_flag(half_flag)
);

// File: tb/strobe_fifo_test.sv
module strobe_fifo_test;
  localparam int W = 9;
  localparam int D = 64;

  logic         clk = 0;
  logic         rst = 1;
  logic         shift_in = 0, shift_out = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic         in_rdy, out_rdy, edge_flag, half_flag;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] q [D];
  int head = 0;
  int cnt  = 0;

  always #10 clk = ~clk;

  strobe_fifo #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .shift_in(shift_in), .din(din), .in_rdy(in_rdy),
    .shift_out(shift_out), .dout(dout), .out_rdy(out_rdy),
    .edge_flag(edge_flag), .half_flag(half_flag)
  );

  function automatic logic exp_edge(int c);
    return (c <= 8) || (c >= 56);
  endfunction

  function automatic logic exp_half(int c);
    return c >= 32;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(in_rdy == (cnt != D), "R3 in_rdy", in_rdy, cnt != D);
    chk(out_rdy == (cnt != 0), "R2/R4 out_rdy", out_rdy, cnt != 0);
    chk(edge_flag == exp_edge(cnt), "R6 edge_flag", edge_flag, exp_edge(cnt));
    chk(half_flag == exp_half(cnt), "R7 half_flag", half_flag, exp_half(cnt));
    if (cnt != 0)
      chk(dout == q[head], "R5/R9 dout order", dout, q[head]);
  endtask

  task automatic step(input logic si, input logic so);
    logic wr, rd;
    @(negedge clk);
    check_outputs();
    din = W'($urandom);
    shift_in = si;
    shift_out = so;
    wr = si && (cnt != D);
    rd = so && (cnt != 0);
    if (wr) q[(head + cnt) % D] = din;
    if (rd) head = (head + 1) % D;
    cnt = cnt + int'(wr) - int'(rd);
  endtask

  task automatic phase(input int n, input int pin, input int pout);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < pin, ($urandom % 100) < pout);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(in_rdy && !out_rdy && !half_flag && edge_flag, "R1 reset state",
        {in_rdy, out_rdy, half_flag, edge_flag}, 4'b1001);
    // R4 shift-out on empty; R2 first write rises out_rdy one clock later
    step(0, 1);
    step(0, 1);
    step(1, 1);
    step(0, 0);
    // R3 fill to full then extra shift-ins
    for (int i = 0; i < 70; i++) step(1, 0);
    // R8 both strobes while full: only shift-out honoured
    step(1, 1);
    step(1, 0);
    // drain to empty then extra shift-outs (R4)
    for (int i = 0; i < 70; i++) step(0, 1);
    // R8 both strobes while empty: only shift-in honoured
    step(1, 1);
    step(0, 0);
    // R8 balanced occupancy with simultaneous strobes
    for (int i = 0; i < 20; i++) step(1, 0);
    for (int i = 0; i < 20; i++) step(1, 1);
    phase(1500, 80, 30);
    phase(1500, 30, 80);
    phase(3000, 55, 55);
    // mid-stream reset (R1)
    @(negedge clk);
    rst = 1;
    shift_in = 0;
    shift_out = 0;
    @(negedge clk);
    rst = 0;
    head = 0;
    cnt = 0;
    chk(in_rdy && !out_rdy && !half_flag && edge_flag, "R1 reset mid-run",
        {in_rdy, out_rdy, half_flag, edge_flag}, 4'b1001);
    phase(500, 60, 50);
    step(0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule